// File: doc/BRIEF.md
# Mirrored-Boundary Address Sequencer for a 5/3 Lifting Stage

This block drives the sample memory of one level of a one-dimensional 5/3 lifting wavelet stage. It emits a pair of read addresses on each cycle, one for the even stream and one for the odd stream. Together the pairs walk a signal that has been mirrored by two samples at its left edge and by one sample at its right edge. No extended sample is ever stored. The mirror comes only from the step added to each address register. The even step is negative for the first move. Both steps are +2 across the body, and both are zero for the final move. The result is that the edge samples are read a second time.

The signal occupies addresses 0 to N-1, where N is given at start. The block also produces write addresses for the in-place results. A write address is the read address delayed by a datapath latency that depends on the transform direction. Each address is written exactly once. A one-cycle done pulse marks the point where the last write has left the block, and from then on a new start is accepted.

Top module: `symext_addr_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the outputs rd_valid, wr_even_valid, wr_odd_valid and done are all 0.
- R2: A start is accepted only when the block is idle and the even length E lies in the range 4 to 2^AW. E is sig_len with bit 0 cleared. In any other case the start has no effect, which means no read pair appears and the run already under way is left unchanged.
- R3: An accepted start makes rd_valid rise in the next cycle. Pair 0 is (even 2, odd 1) and pair 1 is (even 0, odd 1), so the left-mirror move steps the even address by -2 and the odd address by 0.
- R4: For pairs 2 to E/2, both addresses advance by +2 on every cycle. Pair k is (2k-2, 2k-1).
- R5: Pair E/2+1 repeats (E-2, E-1), because the right-mirror step is zero for both streams. rd_valid is high for exactly E/2+2 consecutive cycles, and every read address is below E.
- R6: Bit 0 of sig_len is ignored. An odd value gives the same sequence as the value with that bit cleared.
- R7: Pairs 1 to E/2 are the only pairs that produce writes, one even write and one odd write each. Every even address from 0 to E-2 and every odd address from 1 to E-1 is written exactly once.
- R8: With fwd=1 (forward), an odd write appears DLY_PRED cycles after its read pair and an even write appears DLY_PRED+DLY_UPD cycles after it.
- R9: With fwd=0 (inverse), an even write appears DLY_UPD cycles after its read pair and an odd write appears DLY_PRED+DLY_UPD cycles after it.
- R10: done is a single-cycle pulse in the cycle after the last write strobe of the run. It comes E/2+DLY_PRED+DLY_UPD+1 cycles after the first read pair. A start issued in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a run |
| fwd | input | 1 | 1 selects forward, 0 selects inverse (captured at start) |
| sig_len | input | AW+1 | Signal length N (bit 0 ignored) |
| rd_valid | output | 1 | A read pair is presented |
| rd_even_addr | output | AW | Even-stream read address |
| rd_odd_addr | output | AW | Odd-stream read address |
| wr_even_valid | output | 1 | Even-stream write strobe |
| wr_even_addr | output | AW | Even-stream write address |
| wr_odd_valid | output | 1 | Odd-stream write strobe |
| wr_odd_addr | output | AW | Odd-stream write address |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions check several properties on every cycle:
- the parity of read and write addresses;
- that read addresses stay below the captured length;
- the +2 step across the body;
- that the captured length holds while the block is busy;
- that done lasts only one cycle.

The exact left and right mirror pairs, the per-direction write delays, the exactly-once coverage of writes and the done timing are shown only by the bench. The bench compares every output on every cycle of each run against a reference sequence that it computes itself. It does this for random lengths and directions. It also covers the smallest and largest legal lengths, odd lengths, rejected lengths, a start raised mid-run and back-to-back runs.

// File: rtl/symext_addr_gen.sv
module symext_addr_gen #(
  parameter int AW       = 8,
  parameter int DLY_PRED = 2,
  parameter int DLY_UPD  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fwd,
  input  logic [AW:0]   sig_len,
  output logic          rd_valid,
  output logic [AW-1:0] rd_even_addr,
  output logic [AW-1:0] rd_odd_addr,
  output logic          wr_even_valid,
  output logic [AW-1:0] wr_even_addr,
  output logic          wr_odd_valid,
  output logic [AW-1:0] wr_odd_addr,
  output logic          done
);
  localparam int MAXD = DLY_PRED + DLY_UPD;
  localparam int TE_F = MAXD;
  localparam int TO_F = DLY_PRED;
  localparam int TE_I = DLY_UPD;
  localparam int TO_I = MAXD;

  logic          running, fwd_q, busy_q;
  logic [AW-1:0] half_q, cnt, ea, oa, e_inc, o_inc;
  logic [MAXD:1] p_we;
  logic [AW-1:0] p_e [1:MAXD];
  logic [AW-1:0] p_o [1:MAXD];

  wire [AW:0] len_even = {sig_len[AW:1], 1'b0};
  wire        len_ok   = (len_even >= (AW+1)'(4)) && (len_even <= {1'b1, {AW{1'b0}}});
  wire        busy     = running | (|p_we);
  wire        accept   = start & ~busy & len_ok;
  wire        last     = (cnt == half_q + AW'(1));
  wire        eligible = running && (cnt != '0) && !last;

  always_comb begin
    if (cnt == '0) begin
      e_inc = {{(AW-1){1'b1}}, 1'b0};
      o_inc = '0;
    end else if (cnt == half_q) begin
      e_inc = '0;
      o_inc = '0;
    end else begin
      e_inc = AW'(2);
      o_inc = AW'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      fwd_q   <= 1'b1;
      cnt     <= '0;
      half_q  <= '0;
      ea      <= '0;
      oa      <= '0;
    end else if (accept) begin
      running <= 1'b1;
      fwd_q   <= fwd;
      cnt     <= '0;
      half_q  <= len_even[AW:1];
      ea      <= AW'(2);
      oa      <= AW'(1);
    end else if (running) begin
      if (last) begin
        running <= 1'b0;
      end else begin
        cnt <= cnt + AW'(1);
        ea  <= ea + e_inc;
        oa  <= oa + o_inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_we   <= '0;
      busy_q <= 1'b0;
    end else begin
      p_we   <= {p_we[MAXD-1:1], eligible};
      busy_q <= busy;
    end
  end

  always_ff @(posedge clk) begin
    p_e[1] <= ea;
    p_o[1] <= oa;
    for (int j = 2; j <= MAXD; j++) begin
      p_e[j] <= p_e[j-1];
      p_o[j] <= p_o[j-1];
    end
  end

  assign rd_valid      = running;
  assign rd_even_addr  = ea;
  assign rd_odd_addr   = oa;
  assign wr_even_valid = fwd_q ? p_we[TE_F] : p_we[TE_I];
  assign wr_even_addr  = fwd_q ? p_e[TE_F]  : p_e[TE_I];
  assign wr_odd_valid  = fwd_q ? p_we[TO_F] : p_we[TO_I];
  assign wr_odd_addr   = fwd_q ? p_o[TO_F]  : p_o[TO_I];
  assign done          = busy_q & ~busy;

  assert_rd_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!rd_even_addr[0] && rd_odd_addr[0]));

  assert_body_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt > AW'(1) && cnt <= half_q) |->
      (rd_even_addr == $past(rd_even_addr) + AW'(2) && rd_odd_addr == $past(rd_odd_addr) + AW'(2)));

  assert_rd_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((AW+1)'(rd_even_addr) < {half_q, 1'b0} && (AW+1)'(rd_odd_addr) < {half_q, 1'b0}));

  assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(half_q));

  assert_wr_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_odd_valid |-> wr_odd_addr[0]) and (wr_even_valid |-> !wr_even_addr[0]));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/symext_addr_gen_tb.sv
`timescale 1ns/1ps
module symext_addr_gen_tb;
  localparam int AW = 8, DP = 2, DU = 1, MAXD = DP + DU;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, fwd = 1'b1;
  logic [AW:0] sig_len = '0;
  logic rd_valid, wr_even_valid, wr_odd_valid, done;
  logic [AW-1:0] rd_even_addr, rd_odd_addr, wr_even_addr, wr_odd_addr;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  symext_addr_gen #(.AW(AW), .DLY_PRED(DP), .DLY_UPD(DU)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fwd(fwd), .sig_len(sig_len),
    .rd_valid(rd_valid), .rd_even_addr(rd_even_addr), .rd_odd_addr(rd_odd_addr),
    .wr_even_valid(wr_even_valid), .wr_even_addr(wr_even_addr),
    .wr_odd_valid(wr_odd_valid), .wr_odd_addr(wr_odd_addr), .done(done));

  function automatic int exp_e(int k, int n);
    if (k == 0) return 2;
    if (k <= n/2) return 2*k - 2;
    return n - 2;
  endfunction

  function automatic int exp_o(int k, int n);
    if (k <= 1) return 1;
    if (k <= n/2) return 2*k - 1;
    return n - 1;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(int raw, bit f, bit poke);
    int n, half, te, to, rdc, wec, woc;
    n = raw & ~1; half = n / 2;
    te = f ? MAXD : DU; to = f ? DP : MAXD;
    rdc = 0; wec = 0; woc = 0;
    sig_len = (AW+1)'(raw); fwd = f; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int c = 0; c <= half + MAXD + 1; c++) begin
      int ke, ko;
      string rt;
      @(negedge clk);
      rt = (c <= 1) ? "R3" : (c <= half) ? "R4" : "R5";
      check("R5", int'(rd_valid), int'(c <= half + 1));
      if (rd_valid) begin
        rdc++;
        check(rt, int'(rd_even_addr), exp_e(c, n));
        check(rt, int'(rd_odd_addr), exp_o(c, n));
      end
      ke = c - te; ko = c - to;
      check("R7", int'(wr_even_valid), int'(ke >= 1 && ke <= half));
      check("R7", int'(wr_odd_valid), int'(ko >= 1 && ko <= half));
      if (wr_even_valid) begin wec++; check(f ? "R8" : "R9", int'(wr_even_addr), exp_e(ke, n)); end
      if (wr_odd_valid) begin woc++; check(f ? "R8" : "R9", int'(wr_odd_addr), exp_o(ko, n)); end
      check("R10", int'(done), int'(c == half + MAXD + 1));
      if (poke && c == 3) begin start = 1'b1; sig_len = (AW+1)'(4); fwd = ~f; end
      if (poke && c == 4) start = 1'b0;
    end
    check((raw & 1) ? "R6" : "R5", rdc, half + 2);
    check("R7", wec, half);
    check("R7", woc, half);
    if (poke) check("R2", rdc, half + 2);
  endtask

  task automatic reject(int raw);
    sig_len = (AW+1)'(raw); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R2", int'(rd_valid), 0);
      check("R2", int'(done), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", int'({rd_valid, wr_even_valid, wr_odd_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'({rd_valid, wr_even_valid, wr_odd_valid, done}), 0);
    run(4, 1'b1, 1'b0);
    run(4, 1'b0, 1'b0);
    run(64, 1'b1, 1'b0);
    run(1 << AW, 1'b0, 1'b0);
    run(33, 1'b1, 1'b0);
    run(20, 1'b0, 1'b1);
    reject(2);
    reject(3);
    reject((1 << AW) + 2);
    run(10, 1'b1, 1'b0);
    for (int i = 0; i < 24; i++) begin
      int raw;
      raw = 2 * int'($urandom_range(2, 1 << (AW-1))) + int'($urandom_range(0, 1));
      if (raw > (1 << AW)) raw = raw & ~1;
      run(raw, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule